// File: doc/BRIEF.md
# Write/Scan Access Arbiter for a Shared Display Memory

This block decides which of two independent clients may drive a single-ported display memory on a given cycle. The host side issues write and read request pulses, each with an address. The display side issues periodic scan request pulses, each naming the row to fetch. A scan uses the same bit lines as an ordinary access, so the two may never run together.

The arbiter grants the earliest request at once. Any request that arrives while the memory is busy waits in a per-source pending slot. The memory releases that slot with a one-cycle completion pulse. On each grant the block steers the matching address to the memory, raises the write enable for writes only, and gives a one-clock start strobe.

Repeated requests are folded together so that power is not spent on redundant accesses. A second request from a source that already has one pending updates the pending entry. A scan of the row that is already being scanned is discarded. Arrival order is tracked across all three sources, and a fixed order breaks ties within one cycle.

Top module: `access_arbiter`

## Requirements
- R1: At most one of grant_wr, grant_rd and grant_scan is high on any cycle; all low means the memory is idle.
- R2: A request sampled on a clock edge while the arbiter is idle shows its grant, mem_strobe and address on the output registers updated at that same edge.
- R3: mem_strobe is high for exactly one clock at the start of each grant. A mem_done pulse that falls in the strobe cycle is ignored.
- R4: While a grant is active and mem_done is low, the grant outputs, mem_addr and mem_we hold their values, and new requests only fill pending slots.
- R5: When mem_done is sampled after the strobe cycle, the next waiting request is granted at that same edge, with no idle cycle. If nothing is waiting, all grants drop at that edge.
- R6: Requests that arrive in the same cycle are served in the order write, then read, then scan.
- R7: Requests that arrive in different cycles are served oldest first, whatever their source.
- R8: mem_addr carries host_addr for a write or read grant and scan_row for a scan grant. mem_we is high for the whole of a write grant and low otherwise.
- R9: A second request from a source whose request is already pending does not produce a second grant. The pending entry takes the newest address.
- R10: A scan request whose row equals the row of the scan currently in progress is dropped and never granted.
- R11: After reset, all grants, mem_strobe and mem_we are low.
- R12: A mem_done pulse while idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_req | input | 1 | Host write request pulse |
| host_rd_req | input | 1 | Host read request pulse |
| host_addr | input | ADDR_W | Address for a host request in the same cycle |
| scan_req | input | 1 | Display scan request pulse |
| scan_row | input | ADDR_W | Row for a scan request in the same cycle |
| mem_done | input | 1 | One-cycle completion pulse from the memory |
| mem_strobe | output | 1 | One-clock start strobe for the granted access |
| mem_we | output | 1 | High during a write grant |
| mem_addr | output | ADDR_W | Address of the granted access |
| grant_wr | output | 1 | Write access in progress |
| grant_rd | output | 1 | Read access in progress |
| grant_scan | output | 1 | Scan access in progress |

## Verification
Request capture and grant release can coincide. The bench provokes this by letting host and scan pulses land in one cycle, and by letting new pulses arrive while a grant is active, so that they must wait for mem_done. It judges the outcome by the order and timing of the grants: write before read before scan on a tie, the oldest first otherwise, and each grant starting on the edge that samples mem_done. It also makes repeated pulses collide with a pending or in-progress access of the same source and confirms that only one grant appears, with the newest address.

// File: rtl/arb_pkg.sv
// Shared constants for the display memory access arbiter.
// Source indices double as same-cycle priority: a lower index wins a tie.
package arb_pkg;
    localparam int NSRC   = 3;
    localparam int SRC_WR = 0;
    localparam int SRC_RD = 1;
    localparam int SRC_SC = 2;
endpackage

// File: rtl/req_capture.sv
// Request capture: one pending slot per source, each with its address.
// Assumes the take vector is one-hot or zero and names the slot granted this cycle.
// A request that arrives for a source that is already pending merges into it, and the
// newest address wins. A scan of the row currently being scanned is dropped.
module req_capture
    import arb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              req,
    input  logic [NSRC-1:0][ADDR_W-1:0]  req_addr,
    input  logic                         scan_inflight,
    input  logic [ADDR_W-1:0]            inflight_addr,
    input  logic [NSRC-1:0]              take,
    output logic [NSRC-1:0]              pend,
    output logic [NSRC-1:0]              eff_valid,
    output logic [NSRC-1:0][ADDR_W-1:0]  eff_addr
);
    logic                         drop_scan;
    logic [NSRC-1:0]              req_kept;
    logic [NSRC-1:0][ADDR_W-1:0]  pend_addr;

    // Detect a scan of the row that is already being fetched.
    always_comb begin
        drop_scan = req[SRC_SC] && scan_inflight && (req_addr[SRC_SC] == inflight_addr);
    end

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_slot
            // Merge an incoming request with the pending slot of the same source.
            always_comb begin
                req_kept[s]  = req[s] && !((s == SRC_SC) && drop_scan);
                eff_valid[s] = pend[s] || req_kept[s];
                eff_addr[s]  = req_kept[s] ? req_addr[s] : pend_addr[s];
            end

            // Hold the slot until it is granted; keep the newest address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend[s]      <= 1'b0;
                    pend_addr[s] <= '0;
                end else begin
                    pend[s]      <= eff_valid[s] && !take[s];
                    pend_addr[s] <= eff_addr[s];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/age_order.sv
// Age order: picks the oldest valid request across all sources.
// Assumes pend is the registered pending vector and eff_valid includes this cycle's arrivals.
// A slot that is already pending is older than one arriving now. Two arrivals in the same
// cycle are ordered by index. Two pending slots use the stored pairwise order.
module age_order
    import arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] eff_valid,
    output logic [NSRC-1:0] sel
);
    logic [NSRC-1:0][NSRC-1:0] older_q;
    logic [NSRC-1:0][NSRC-1:0] older_now;

    generate
        for (genvar j = 0; j < NSRC; j++) begin : g_row
            for (genvar i = 0; i < NSRC; i++) begin : g_col
                // Decide whether source j is ahead of source i this cycle.
                always_comb begin
                    if (i == j)
                        older_now[j][i] = 1'b0;
                    else if (pend[j] && pend[i])
                        older_now[j][i] = older_q[j][i];
                    else if (pend[j] != pend[i])
                        older_now[j][i] = pend[j];
                    else
                        older_now[j][i] = (j < i);
                end
            end
        end

        for (genvar i = 0; i < NSRC; i++) begin : g_win
            // A source wins when it is valid and no valid source is ahead of it.
            always_comb begin
                sel[i] = eff_valid[i];
                for (int j = 0; j < NSRC; j++) begin
                    if (j != i && eff_valid[j] && older_now[j][i])
                        sel[i] = 1'b0;
                end
            end
        end
    endgenerate

    // Remember the pairwise order for slots that stay pending.
    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_now;
    end

    // R7: a non-empty request set always yields exactly one winner.
    assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|eff_valid) |-> ($countones(sel) == 1));
    // R1: never more than one winner.
    assert_winner_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/issue_ctrl.sv
// Issue control: owns the memory, launches the selected access and releases it on done.
// Assumes mem_done arrives no earlier than the cycle after mem_strobe; a done pulse in the
// strobe cycle is ignored. The memory counts as free when idle, or when done is sampled
// after the strobe, so a waiting request starts with no idle cycle.
module issue_ctrl
    import arb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mem_done,
    input  logic [NSRC-1:0]              sel,
    input  logic [NSRC-1:0][ADDR_W-1:0]  eff_addr,
    output logic [NSRC-1:0]              take,
    output logic [NSRC-1:0]              cur,
    output logic                         mem_strobe,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr
);
    logic              busy;
    logic              free;
    logic              launch;
    logic [ADDR_W-1:0] sel_addr;

    // Find the free condition and pick the winner's address.
    always_comb begin
        free     = !busy || (mem_done && !mem_strobe);
        launch   = free && (|sel);
        take     = launch ? sel : '0;
        sel_addr = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (sel[s]) sel_addr = eff_addr[s];
        end
    end

    // Start a grant, hold it, or release it on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cur        <= '0;
            mem_strobe <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
        end else if (launch) begin
            busy       <= 1'b1;
            cur        <= sel;
            mem_strobe <= 1'b1;
            mem_we     <= sel[SRC_WR];
            mem_addr   <= sel_addr;
        end else begin
            mem_strobe <= 1'b0;
            if (free) begin
                busy   <= 1'b0;
                cur    <= '0;
                mem_we <= 1'b0;
            end
        end
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cur));
    assert_strobe_has_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |-> (cur != '0));
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe |=> !mem_strobe);
    assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur != '0) && !mem_done) |=> ($stable(cur) && $stable(mem_addr) && !mem_strobe));
    assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur != '0) && mem_done && !mem_strobe && (|sel)) |=> mem_strobe);
    assert_we_write_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cur[SRC_WR]);
endmodule

// File: rtl/access_arbiter.sv
// Top level: arbitrates host write/read and display scan access to one memory port.
// Assumes request inputs are single-cycle pulses with their address valid in the same
// cycle, and mem_done is a one-cycle pulse that ends the current access.
module access_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_req,
    input  logic              host_rd_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              scan_req,
    input  logic [ADDR_W-1:0] scan_row,
    input  logic              mem_done,
    output logic              mem_strobe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              grant_wr,
    output logic              grant_rd,
    output logic              grant_scan
);
    logic [NSRC-1:0]             req;
    logic [NSRC-1:0][ADDR_W-1:0] req_addr;
    logic [NSRC-1:0]             pend;
    logic [NSRC-1:0]             eff_valid;
    logic [NSRC-1:0][ADDR_W-1:0] eff_addr;
    logic [NSRC-1:0]             sel;
    logic [NSRC-1:0]             take;
    logic [NSRC-1:0]             cur;

    // Gather the three sources into indexed vectors.
    always_comb begin
        req              = '0;
        req[SRC_WR]      = host_wr_req;
        req[SRC_RD]      = host_rd_req;
        req[SRC_SC]      = scan_req;
        req_addr         = '0;
        req_addr[SRC_WR] = host_addr;
        req_addr[SRC_RD] = host_addr;
        req_addr[SRC_SC] = scan_row;
    end

    req_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .req_addr      (req_addr),
        .scan_inflight (cur[SRC_SC]),
        .inflight_addr (mem_addr),
        .take          (take),
        .pend          (pend),
        .eff_valid     (eff_valid),
        .eff_addr      (eff_addr)
    );

    age_order u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .eff_valid (eff_valid),
        .sel       (sel)
    );

    issue_ctrl #(.ADDR_W(ADDR_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_done   (mem_done),
        .sel        (sel),
        .eff_addr   (eff_addr),
        .take       (take),
        .cur        (cur),
        .mem_strobe (mem_strobe),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr)
    );

    // Split the current grant into named outputs.
    always_comb begin
        grant_wr   = cur[SRC_WR];
        grant_rd   = cur[SRC_RD];
        grant_scan = cur[SRC_SC];
    end

    // R10: a scan that repeats the in-progress row never restarts the memory.
    assert_scan_repeat_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && grant_scan && (scan_row == mem_addr) && !pend[SRC_SC] && !mem_done)
        |=> !mem_strobe);
endmodule

// File: tb/test_access_arbiter.sv
// Directed bench: one task per scenario. Inputs change at the falling edge and outputs are
// checked at the next falling edge. Output code is {grant_wr, grant_rd, grant_scan, strobe, we}.
module test_access_arbiter;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr, rd, sc, done;
    logic [AW-1:0] haddr, srow;
    logic          mem_strobe, mem_we, grant_wr, grant_rd, grant_scan;
    logic [AW-1:0] mem_addr;
    int            total = 0;
    int            bad = 0;
    logic          finished = 1'b0;

    always #5 clk = ~clk;

    access_arbiter #(.ADDR_W(AW)) i_access_arbiter (
        .clk(clk), .rst_n(rst_n), .host_wr_req(wr), .host_rd_req(rd), .host_addr(haddr),
        .scan_req(sc), .scan_row(srow), .mem_done(done), .mem_strobe(mem_strobe),
        .mem_we(mem_we), .mem_addr(mem_addr), .grant_wr(grant_wr), .grant_rd(grant_rd),
        .grant_scan(grant_scan)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [4:0] exp_code, input logic [AW-1:0] exp_addr,
                       input logic use_addr);
        logic [4:0] act;
        act = {grant_wr, grant_rd, grant_scan, mem_strobe, mem_we};
        total++;
        if (act !== exp_code || (use_addr && mem_addr !== exp_addr)) begin
            bad++;
            $display("FAIL %s: code=%b addr=%h expected code=%b addr=%h",
                     tag, act, mem_addr, exp_code, exp_addr);
        end
    endtask

    task automatic clear_in();
        wr = 0; rd = 0; sc = 0; done = 0;
    endtask

    // R11: outputs after reset.
    task automatic t_reset();
        clear_in(); haddr = 0; srow = 0; rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        chk("R11 reset state", 5'b00000, 0, 1'b0);
    endtask

    // R2, R3, R4, R5, R8: a single write from idle.
    task automatic t_single_write();
        wr = 1; haddr = 8'h12; step();
        wr = 0; chk("R2 write granted at once", 5'b10011, 8'h12, 1'b1);
        step(); chk("R3 strobe one clock, R8 we held", 5'b10001, 8'h12, 1'b1);
        step(); chk("R4 grant held without done", 5'b10001, 8'h12, 1'b1);
        done = 1; step();
        done = 0; chk("R5 release to idle", 5'b00000, 0, 1'b0);
    endtask

    // R6: write, read and scan in the same cycle.
    task automatic t_same_cycle();
        wr = 1; rd = 1; sc = 1; haddr = 8'h44; srow = 8'h05; step();
        clear_in(); chk("R6 write first", 5'b10011, 8'h44, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R6 read second, R5 no gap", 5'b01010, 8'h44, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R6 scan third, R8 scan row", 5'b00110, 8'h05, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R6 idle after all", 5'b00000, 0, 1'b0);
    endtask

    // R7, R4: scan arrives before read while a write is running.
    task automatic t_arrival_order();
        wr = 1; haddr = 8'h20; step();
        wr = 0; chk("R7 write granted", 5'b10011, 8'h20, 1'b1);
        sc = 1; srow = 8'h07; step();
        sc = 0; chk("R4 scan held", 5'b10001, 8'h20, 1'b1);
        rd = 1; haddr = 8'h33; step();
        rd = 0; chk("R4 read held", 5'b10001, 8'h20, 1'b1);
        done = 1; step();
        done = 0; chk("R7 older scan first", 5'b00110, 8'h07, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R7 read next", 5'b01010, 8'h33, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R7 idle", 5'b00000, 0, 1'b0);
    endtask

    // R9: two reads while a write runs merge into one, with the newest address.
    task automatic t_merge();
        wr = 1; haddr = 8'h01; step();
        wr = 0; rd = 1; haddr = 8'h40; step();
        haddr = 8'h41; step();
        rd = 0; chk("R9 write still held", 5'b10001, 8'h01, 1'b1);
        done = 1; step();
        done = 0; chk("R9 merged read newest addr", 5'b01010, 8'h41, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R9 no second read", 5'b00000, 0, 1'b0);
    endtask

    // R10: a repeat scan of the same row is dropped; a new row waits.
    task automatic t_scan_drop();
        sc = 1; srow = 8'h09; step();
        chk("R10 scan granted", 5'b00110, 8'h09, 1'b1);
        step(); step();
        sc = 0; done = 1; step();
        done = 0; chk("R10 repeat row dropped", 5'b00000, 0, 1'b0);
        sc = 1; srow = 8'h03; step();
        srow = 8'h04; step();
        sc = 0; chk("R10 first scan running", 5'b00100, 8'h03, 1'b1);
        done = 1; step();
        done = 0; chk("R10 other row served", 5'b00110, 8'h04, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R10 idle", 5'b00000, 0, 1'b0);
    endtask

    // R12: done while idle, then a read from idle.
    task automatic t_done_idle();
        done = 1; step();
        done = 0; chk("R12 done while idle", 5'b00000, 0, 1'b0);
        rd = 1; haddr = 8'h5A; step();
        rd = 0; chk("R2 read from idle", 5'b01010, 8'h5A, 1'b1);
        step(); done = 1; step();
        done = 0; chk("R12 read released", 5'b00000, 0, 1'b0);
    endtask

    // R3: done in the strobe cycle is ignored.
    task automatic t_early_done();
        wr = 1; haddr = 8'h66; step();
        wr = 0; done = 1; step();
        done = 0; chk("R3 early done ignored", 5'b10001, 8'h66, 1'b1);
        done = 1; step();
        done = 0; chk("R3 released by later done", 5'b00000, 0, 1'b0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_single_write();
        t_same_cycle();
        t_arrival_order();
        t_merge();
        t_scan_drop();
        t_done_idle();
        t_early_done();
        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
        end
    end
endmodule